// File: doc/BRIEF.md
# Sync Output Source Selector with Polarity Correction

This block produces the processed horizontal and vertical sync outputs of a display sync path. Each output is drawn from one of three sources. The first is a pair of internal free-running pulse trains. The second is the separate horizontal and vertical sync inputs, passed straight through. The third is a composite sync input: the horizontal output follows the composite signal, and the vertical output carries a frame pulse recovered from the long low intervals of the composite signal.

Every input passes through a resynchroniser. The two external outputs are registered. Each output has its own enable, and a disabled output rests at its inactive high level.

Polarity can be set by hand with one invert bit per output. In automatic mode, each input's active level is learned from the signal itself. The level the signal spends the minority of each period in is taken as active, and the signal is normalised to active-low before the invert bit is applied. The free-running pulses are always active-low and ignore the invert bits.

Top module: `sync_out_sel`

## Requirements
- R1: When `h_en_i` is 0, `hsync_o` is 1; when `v_en_i` is 0, `vsync_o` is 1. During reset both outputs are 1.
- R2: With `free_run_i`=1, `hsync_o` is low for `H_WIDTH` cycles out of every `H_PERIOD` cycles, and `vsync_o` is low for `V_WIDTH` cycles out of every `V_PERIOD` cycles. This holds whatever value `comp_mode_i` has.
- R3: With `free_run_i`=0, `comp_mode_i`=0 and `auto_pol_i`=0, `hsync_o` equals `hsync_i` XOR `h_inv_i` and `vsync_o` equals `vsync_i` XOR `v_inv_i`. The outputs follow the inputs `SYNC_STAGES`+1 cycles after an input change.
- R4: With `free_run_i`=0 and `comp_mode_i`=1, `hsync_o` equals the (polarity-normalised) `csync_i` XOR `h_inv_i`.
- R5: In composite mode, the extracted vertical pulse goes active once the normalised composite input has been low for `VEXT_THRESH` consecutive cycles. A shorter low pulse never activates it. `vsync_o` carries the extracted pulse as active-low, XOR `v_inv_i`.
- R6: The extracted vertical pulse is released on the first high cycle of the normalised composite input. `vsync_o` returns high no more than `SYNC_STAGES`+2 cycles after `csync_i` rises.
- R7: With `auto_pol_i`=1, each input's active level is re-estimated at every rising edge of that input. The estimate is high if the input spent fewer cycles high than low over the last period, and low if it spent more. The output is then active-low, with the invert bit applied on top.
- R8: In free-running mode the invert bits have no effect, and the pulses stay active-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_i | input | 1 | Separate horizontal sync input |
| vsync_i | input | 1 | Separate vertical sync input |
| csync_i | input | 1 | Composite sync input |
| free_run_i | input | 1 | 1 selects the internal free-running pulses |
| comp_mode_i | input | 1 | 1 selects the composite source when not free-running |
| h_inv_i | input | 1 | Invert horizontal output |
| v_inv_i | input | 1 | Invert vertical output |
| auto_pol_i | input | 1 | 1 enables automatic input polarity normalisation |
| h_en_i | input | 1 | Horizontal output enable |
| v_en_i | input | 1 | Vertical output enable |
| hsync_o | output | 1 | Processed horizontal sync |
| vsync_o | output | 1 | Processed vertical sync |

## Verification
The free-running trains are counted over whole numbers of periods, with the mode bit and the invert bits both set and cleared, so that width errors and any leak of the invert bits show up. The composite source is tried with one low pulse shorter than the extraction threshold and one longer than it. This separates false extraction from missed extraction, and it also checks the release timing after the rising edge. The automatic-polarity detector is trained on both a short-high pulse train and a short-low pulse train. Each trained state is then probed with steady levels, with and without the invert bit, so that a wrong estimate is distinguished from a wrong inversion.

// File: rtl/sync_pkg.sv
package sync_pkg;

   typedef enum logic [1:0] {
      SRC_SEP  = 2'd0,
      SRC_COMP = 2'd1,
      SRC_FREE = 2'd2
   } src_e;

   localparam int IDX_H  = 0;
   localparam int IDX_V  = 1;
   localparam int IDX_CS = 2;
   localparam int N_IN   = 3;

   function automatic src_e pick_src(input logic free_run, input logic comp);
      if (free_run)  return SRC_FREE;
      else if (comp) return SRC_COMP;
      else           return SRC_SEP;
   endfunction

endpackage

// File: rtl/sync_resync.sv
module sync_resync #(
   parameter int W       = 3,
   parameter int STAGES  = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("sync_resync: STAGES must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '1;
         else if (s == 0) stg[s] <= d_i;
         else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sync_freerun.sv
module sync_freerun #(
   parameter int PERIOD = 32,
   parameter int WIDTH  = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic pulse_n_o
);
   localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

   if (WIDTH < 1 || WIDTH >= PERIOD) begin : g_bad_width
      $error("sync_freerun: WIDTH must be in 1..PERIOD-1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt <= '0;
      else if (cnt == CW'(PERIOD - 1))   cnt <= '0;
      else                               cnt <= cnt + 1'b1;
   end

   assign pulse_n_o = (cnt >= CW'(WIDTH));

   assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(PERIOD - 1));

   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CW'(PERIOD - 1)) |=> (cnt == '0));
endmodule

// File: rtl/sync_pol_detect.sv
module sync_pol_detect #(
   parameter int CW = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic act_high_o
);
   if (CW < 2) begin : g_bad_cw
      $error("sync_pol_detect: CW must be at least 2");
   end

   logic          prev;
   logic [CW-1:0] hi_cnt, lo_cnt;
   logic          rise;

   assign rise = lvl_i & ~prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev       <= 1'b1;
         hi_cnt     <= '0;
         lo_cnt     <= '0;
         act_high_o <= 1'b0;
      end else begin
         prev <= lvl_i;
         if (rise) begin
            if (hi_cnt < lo_cnt)      act_high_o <= 1'b1;
            else if (lo_cnt < hi_cnt) act_high_o <= 1'b0;
            hi_cnt <= CW'(1);
            lo_cnt <= '0;
         end else if (lvl_i) begin
            if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
         end else begin
            if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
         end
      end
   end

   assert_pol_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> $stable(act_high_o));
endmodule

// File: rtl/sync_vext.sv
module sync_vext #(
   parameter int THRESH = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_i,
   output logic vext_n_o
);
   localparam int CW = $clog2(THRESH + 1);

   if (THRESH < 2) begin : g_bad_thresh
      $error("sync_vext: THRESH must be at least 2");
   end

   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt  <= '0;
         vext_n_o <= 1'b1;
      end else if (cs_n_i) begin
         low_cnt  <= '0;
         vext_n_o <= 1'b1;
      end else begin
         if (low_cnt != CW'(THRESH)) low_cnt <= low_cnt + 1'b1;
         if (low_cnt >= CW'(THRESH - 1)) vext_n_o <= 1'b0;
      end
   end

   assert_vext_needs_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vext_n_o) |-> $past(!cs_n_i));

   assert_vext_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!vext_n_o && cs_n_i) |=> vext_n_o);
endmodule

// File: rtl/sync_out_sel.sv
module sync_out_sel #(
   parameter int SYNC_STAGES = 2,
   parameter int H_PERIOD    = 32,
   parameter int H_WIDTH     = 4,
   parameter int V_PERIOD    = 256,
   parameter int V_WIDTH     = 16,
   parameter int VEXT_THRESH = 8,
   parameter int POL_CW      = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hsync_i,
   input  logic vsync_i,
   input  logic csync_i,
   input  logic free_run_i,
   input  logic comp_mode_i,
   input  logic h_inv_i,
   input  logic v_inv_i,
   input  logic auto_pol_i,
   input  logic h_en_i,
   input  logic v_en_i,
   output logic hsync_o,
   output logic vsync_o
);
   import sync_pkg::*;

   if (V_PERIOD < H_PERIOD) begin : g_bad_periods
      $error("sync_out_sel: V_PERIOD must not be shorter than H_PERIOD");
   end

   logic [N_IN-1:0] raw, synced, act_high, norm;
   logic            fr_h_n, fr_v_n, vext_n;
   logic            h_src, v_src;
   src_e            src;

   assign raw[IDX_H]  = hsync_i;
   assign raw[IDX_V]  = vsync_i;
   assign raw[IDX_CS] = csync_i;

   sync_resync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_resync (
      .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(synced));

   for (genvar i = 0; i < N_IN; i++) begin : g_pol
      sync_pol_detect #(.CW(POL_CW)) u_det (
         .clk(clk), .rst_n(rst_n), .lvl_i(synced[i]), .act_high_o(act_high[i]));
      assign norm[i] = auto_pol_i ? (synced[i] ^ act_high[i]) : synced[i];
   end

   sync_freerun #(.PERIOD(H_PERIOD), .WIDTH(H_WIDTH)) u_fr_h (
      .clk(clk), .rst_n(rst_n), .pulse_n_o(fr_h_n));

   sync_freerun #(.PERIOD(V_PERIOD), .WIDTH(V_WIDTH)) u_fr_v (
      .clk(clk), .rst_n(rst_n), .pulse_n_o(fr_v_n));

   sync_vext #(.THRESH(VEXT_THRESH)) u_vext (
      .clk(clk), .rst_n(rst_n), .cs_n_i(norm[IDX_CS]), .vext_n_o(vext_n));

   assign src = pick_src(free_run_i, comp_mode_i);

   always_comb begin
      unique case (src)
         SRC_FREE: begin
            h_src = fr_h_n;
            v_src = fr_v_n;
         end
         SRC_COMP: begin
            h_src = norm[IDX_CS] ^ h_inv_i;
            v_src = vext_n ^ v_inv_i;
         end
         default: begin
            h_src = norm[IDX_H] ^ h_inv_i;
            v_src = norm[IDX_V] ^ v_inv_i;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsync_o <= 1'b1;
         vsync_o <= 1'b1;
      end else begin
         hsync_o <= h_en_i ? h_src : 1'b1;
         vsync_o <= v_en_i ? v_src : 1'b1;
      end
   end

   assert_h_disabled_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !h_en_i |=> hsync_o);

   assert_v_disabled_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !v_en_i |=> vsync_o);
endmodule

// File: tb/test_sync_out_sel.sv
module test_sync_out_sel;
   localparam int SS = 2, HP = 32, HW = 4, VP = 256, VW = 16, VT = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic hsync_i = 1'b1, vsync_i = 1'b1, csync_i = 1'b1;
   logic free_run_i = 1'b0, comp_mode_i = 1'b0, h_inv_i = 1'b0, v_inv_i = 1'b0;
   logic auto_pol_i = 1'b0, h_en_i = 1'b1, v_en_i = 1'b1;
   logic hsync_o, vsync_o;
   int   errors = 0, checks = 0;

   always #2.5 clk = ~clk;

   sync_out_sel #(.SYNC_STAGES(SS), .H_PERIOD(HP), .H_WIDTH(HW), .V_PERIOD(VP),
                  .V_WIDTH(VW), .VEXT_THRESH(VT), .POL_CW(12)) i_sync_out_sel (
      .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .vsync_i(vsync_i), .csync_i(csync_i),
      .free_run_i(free_run_i), .comp_mode_i(comp_mode_i), .h_inv_i(h_inv_i),
      .v_inv_i(v_inv_i), .auto_pol_i(auto_pol_i), .h_en_i(h_en_i), .v_en_i(v_en_i),
      .hsync_o(hsync_o), .vsync_o(vsync_o));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic count_lows(input int n, output int h_lows, output int v_lows);
      h_lows = 0; v_lows = 0;
      for (int k = 0; k < n; k++) begin
         tick(1);
         if (!hsync_o) h_lows++;
         if (!vsync_o) v_lows++;
      end
   endtask

   task automatic t_reset;
      tick(2);
      check("R1 reset hsync_o", int'(hsync_o), 1);
      check("R1 reset vsync_o", int'(vsync_o), 1);
      rst_n = 1'b1;
      tick(6);
   endtask

   task automatic t_passthrough;
      free_run_i = 0; comp_mode_i = 0; auto_pol_i = 0; h_inv_i = 0; v_inv_i = 0;
      hsync_i = 0; vsync_i = 1;
      tick(SS + 1);
      check("R3 hsync_o follows low hsync_i", int'(hsync_o), 0);
      check("R3 vsync_o follows high vsync_i", int'(vsync_o), 1);
      hsync_i = 1; vsync_i = 0;
      tick(SS + 1);
      check("R3 hsync_o follows high hsync_i", int'(hsync_o), 1);
      check("R3 vsync_o follows low vsync_i", int'(vsync_o), 0);
      h_inv_i = 1; v_inv_i = 1;
      tick(2);
      check("R3 hsync_o inverted", int'(hsync_o), 0);
      check("R3 vsync_o inverted", int'(vsync_o), 1);
      h_inv_i = 0; v_inv_i = 0; hsync_i = 1; vsync_i = 1;
      tick(SS + 2);
   endtask

   task automatic t_enable;
      hsync_i = 0; vsync_i = 0;
      h_en_i = 0; v_en_i = 0;
      tick(SS + 2);
      check("R1 disabled hsync_o high", int'(hsync_o), 1);
      check("R1 disabled vsync_o high", int'(vsync_o), 1);
      h_en_i = 1;
      tick(2);
      check("R1 h enabled, hsync_o low", int'(hsync_o), 0);
      check("R1 v still disabled", int'(vsync_o), 1);
      v_en_i = 1; hsync_i = 1; vsync_i = 1;
      tick(SS + 2);
   endtask

   task automatic t_freerun(input logic comp, input logic inv);
      int hl, vl;
      free_run_i = 1; comp_mode_i = comp; h_inv_i = inv; v_inv_i = inv;
      hsync_i = 0; vsync_i = 0; csync_i = 0;
      tick(3);
      count_lows(2 * VP, hl, vl);
      check(inv ? "R8 h free-run width with invert set" : "R2 h free-run low cycles",
            hl, 2 * VP / HP * HW);
      check(inv ? "R8 v free-run width with invert set" : "R2 v free-run low cycles",
            vl, 2 * VW);
      free_run_i = 0; comp_mode_i = 0; h_inv_i = 0; v_inv_i = 0;
      hsync_i = 1; vsync_i = 1; csync_i = 1;
      tick(SS + 2);
   endtask

   task automatic t_composite;
      int vlows;
      comp_mode_i = 1; auto_pol_i = 0; csync_i = 1;
      tick(10);
      check("R5 idle extracted vsync high", int'(vsync_o), 1);
      csync_i = 0;
      vlows = 0;
      for (int k = 0; k < VT - 3; k++) begin tick(1); if (!vsync_o) vlows++; end
      check("R4 hsync_o follows composite low", int'(hsync_o), 0);
      csync_i = 1;
      for (int k = 0; k < 10; k++) begin tick(1); if (!vsync_o) vlows++; end
      check("R5 short composite pulse not extracted", vlows, 0);
      check("R4 hsync_o follows composite high", int'(hsync_o), 1);
      csync_i = 0;
      tick(VT + 12);
      check("R5 long composite pulse extracted", int'(vsync_o), 0);
      csync_i = 1;
      tick(SS + 2);
      check("R6 extracted vsync released", int'(vsync_o), 1);
      v_inv_i = 1;
      tick(2);
      check("R5 extracted vsync with invert idle low", int'(vsync_o), 0);
      v_inv_i = 0; comp_mode_i = 0;
      tick(SS + 2);
   endtask

   task automatic train_h(input int hi_len, input int lo_len);
      for (int p = 0; p < 4; p++) begin
         hsync_i = 1; tick(hi_len);
         hsync_i = 0; tick(lo_len);
      end
   endtask

   task automatic t_autopol;
      auto_pol_i = 1; comp_mode_i = 0; free_run_i = 0; h_inv_i = 0;
      train_h(3, 17);
      hsync_i = 0; tick(10);
      check("R7 active-high input idle -> output high", int'(hsync_o), 1);
      hsync_i = 1; tick(SS + 2);
      check("R7 active-high input active -> output low", int'(hsync_o), 0);
      h_inv_i = 1; tick(2);
      check("R7 invert applied after normalisation", int'(hsync_o), 1);
      h_inv_i = 0;
      train_h(17, 3);
      hsync_i = 1; tick(SS + 2);
      check("R7 active-low input idle -> output high", int'(hsync_o), 1);
      hsync_i = 0; tick(SS + 2);
      check("R7 active-low input active -> output low", int'(hsync_o), 0);
      hsync_i = 1; auto_pol_i = 0;
      tick(SS + 2);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_passthrough();
      t_enable();
      t_freerun(1'b0, 1'b0);
      t_freerun(1'b1, 1'b1);
      t_composite();
      t_autopol();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule